// File: doc/BRIEF.md
# Level-Sensitive Interrupt Controller with Reset-Switch Latch

This block gathers up to 32 interrupt sources into one interrupt line toward a CPU. It is reached over a simple word-wide memory-mapped register bus. A cause register shows which sources are active. Most cause bits simply mirror the synchronized level of their source, so they clear by themselves when the source lets go. The one exception is the reset-switch cause. It is captured when the switch is pressed and stays set until software clears it by writing a one to that bit. The same cause register also carries a live, active-low view of the switch itself.

An enable mask chooses which causes may reach the CPU. The interrupt output is a registered OR of the enabled causes. A separate control register lets software ask for a platform reset. Writing zero to it produces a fixed-width reset-request pulse. All asynchronous inputs pass through a synchronizer before any logic sees them.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: Every cause bit other than bit 1 and bit 16 equals its source input after a two-flop synchronizer. A source change applied before clock edge k is readable at offset 0x00 after edge k+1, and the bit returns to 0 by itself when the source drops.
- R2: The enable mask is read and written as a whole word at offset 0x04, and it resets to all zeros. A 1 in a bit position enables the cause bit in the same position.
- R3: Cause bit 1 (reset-switch cause) is set on the press of the switch, which is a 1-to-0 transition of the synchronized active-low switch input. Once set, it stays set through release until software clears it.
- R4: A write to offset 0x00 clears cause bit 1 when write-data bit 1 is 1. Write-data bit 1 equal to 0 leaves it unchanged, and no write to 0x00 alters any level cause. When a press is detected in the same cycle as a clearing write, the bit ends up set.
- R5: Cause bit 16 reads the synchronized switch input directly, so it is 0 while the switch is held and 1 when it is released. It never contributes to the interrupt output.
- R6: cpu_irq is 1 exactly when, in the previous cycle, some cause bit other than bit 16 was 1 together with its mask bit.
- R7: Writing the value 0x00000000 to offset 0x24 raises plat_rst_req from the next cycle on for exactly 16 cycles. Another such write during the pulse restarts the 16-cycle count.
- R8: Writing any nonzero value to offset 0x24 has no effect, and plat_rst_req stays low.
- R9: Reads of offset 0x24 and of any offset other than 0x00 and 0x04 return zero.
- R10: Source inputs 1 and 16 have no effect on the cause register or on cpu_irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| src_lvl | input | 32 | Asynchronous level interrupt sources |
| rsw_n | input | 1 | Asynchronous reset switch, low while pressed |
| cpu_irq | output | 1 | Combined registered interrupt to the CPU |
| plat_rst_req | output | 1 | Platform reset request pulse |

## Verification
Two functions can meet in one cycle: a press edge that sets the reset-switch cause, and a software write that clears it. The bench provokes this by lowering the switch input and placing the clearing write on exactly the clock edge at which the synchronized falling edge is detected. It then checks that the cause bit reads 1 afterwards. A second overlap, a level source held high during an all-ones write to the cause register, is judged by checking that the level bit survives while the latched bit is cleared.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
   localparam int unsigned DEF_NSRC      = 32;
   localparam int unsigned DEF_ADDR_W    = 8;
   localparam int unsigned DEF_SYNC      = 2;
   localparam int unsigned DEF_PULSE     = 16;
   localparam int unsigned DEF_RSW_BIT   = 1;
   localparam int unsigned DEF_STATE_BIT = 16;
   localparam logic [7:0]  DEF_OFF_CAUSE = 8'h00;
   localparam logic [7:0]  DEF_OFF_MASK  = 8'h04;
   localparam logic [7:0]  DEF_OFF_RST   = 8'h24;

   typedef enum logic [1:0] {
      ACC_NONE  = 2'd0,
      ACC_CAUSE = 2'd1,
      ACC_MASK  = 2'd2,
      ACC_RST   = 2'd3
   } acc_sel_e;
endpackage

// File: rtl/lvl_irq_sync.sv
module lvl_irq_sync #(
   parameter int unsigned W       = 32,
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_async,
   output logic [W-1:0] q_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("lvl_irq_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stage_q[s] <= {W{RST_VAL}};
         end else if (s == 0) begin
            stage_q[s] <= d_async;
         end else begin
            stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/lvl_irq_rsw_latch.sv
module lvl_irq_rsw_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic sw_sync_n,
   input  logic clr,
   output logic latched
);
   logic sw_prev_q;
   logic press;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sw_prev_q <= 1'b1;
      else        sw_prev_q <= sw_sync_n;
   end

   assign press = sw_prev_q & ~sw_sync_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     latched <= 1'b0;
      else if (press) latched <= 1'b1;
      else if (clr)   latched <= 1'b0;
   end

   assert_press_sets_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      press |=> latched);
   assert_latch_holds_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (latched && !press && !clr) |=> latched);
   assert_clear_drops_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !press) |=> !latched);
endmodule

// File: rtl/lvl_irq_rst_pulse.sv
module lvl_irq_rst_pulse #(
   parameter int unsigned PULSE_LEN = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic req
);
   localparam int unsigned CW = $clog2(PULSE_LEN + 1);

   if (PULSE_LEN < 1) begin : g_bad_len
      $error("lvl_irq_rst_pulse: PULSE_LEN must be positive");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt_q <= '0;
      else if (fire)        cnt_q <= CW'(PULSE_LEN);
      else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
   end

   assign req = (cnt_q != '0);

   assert_fire_starts_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> req);
   assert_pulse_ends_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req) |-> ($past(cnt_q) == CW'(1) && !$past(fire)));
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
   import lvl_irq_pkg::*;
#(
   parameter int unsigned NSRC      = DEF_NSRC,
   parameter int unsigned ADDR_W    = DEF_ADDR_W,
   parameter int unsigned SYNC      = DEF_SYNC,
   parameter int unsigned PULSE_LEN = DEF_PULSE,
   parameter int unsigned RSW_BIT   = DEF_RSW_BIT,
   parameter int unsigned STATE_BIT = DEF_STATE_BIT,
   parameter logic [ADDR_W-1:0] OFF_CAUSE = ADDR_W'(DEF_OFF_CAUSE),
   parameter logic [ADDR_W-1:0] OFF_MASK  = ADDR_W'(DEF_OFF_MASK),
   parameter logic [ADDR_W-1:0] OFF_RST   = ADDR_W'(DEF_OFF_RST)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [NSRC-1:0]   bus_wdata,
   output logic [NSRC-1:0]   bus_rdata,
   input  logic [NSRC-1:0]   src_lvl,
   input  logic              rsw_n,
   output logic              cpu_irq,
   output logic              plat_rst_req
);
   localparam logic [NSRC-1:0] RSW_ONEHOT   = NSRC'(1) << RSW_BIT;
   localparam logic [NSRC-1:0] STATE_ONEHOT = NSRC'(1) << STATE_BIT;
   localparam logic [NSRC-1:0] LEVEL_BITS   = ~(RSW_ONEHOT | STATE_ONEHOT);
   localparam logic [NSRC-1:0] IRQ_BITS     = ~STATE_ONEHOT;

   if (RSW_BIT >= NSRC || STATE_BIT >= NSRC || RSW_BIT == STATE_BIT) begin : g_bad_bits
      $error("lvl_irq_ctrl: RSW_BIT and STATE_BIT must be distinct and below NSRC");
   end
   if (OFF_CAUSE == OFF_MASK || OFF_CAUSE == OFF_RST || OFF_MASK == OFF_RST) begin : g_bad_off
      $error("lvl_irq_ctrl: register offsets must differ");
   end

   acc_sel_e        sel;
   logic [NSRC-1:0] src_sync;
   logic [0:0]      rsw_sync;
   logic            rsw_latched;
   logic [NSRC-1:0] mask_q;
   logic [NSRC-1:0] cause;
   logic            clr_rsw;
   logic            fire_rst;

   always_comb begin
      if      (bus_addr == OFF_CAUSE) sel = ACC_CAUSE;
      else if (bus_addr == OFF_MASK)  sel = ACC_MASK;
      else if (bus_addr == OFF_RST)   sel = ACC_RST;
      else                            sel = ACC_NONE;
   end

   lvl_irq_sync #(.W(NSRC), .STAGES(SYNC), .RST_VAL(1'b0)) u_src_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (src_lvl),
      .q_sync  (src_sync)
   );

   lvl_irq_sync #(.W(1), .STAGES(SYNC), .RST_VAL(1'b1)) u_rsw_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (rsw_n),
      .q_sync  (rsw_sync)
   );

   assign clr_rsw  = bus_wr && (sel == ACC_CAUSE) && bus_wdata[RSW_BIT];
   assign fire_rst = bus_wr && (sel == ACC_RST) && (bus_wdata == '0);

   lvl_irq_rsw_latch u_rsw_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .sw_sync_n (rsw_sync[0]),
      .clr       (clr_rsw),
      .latched   (rsw_latched)
   );

   lvl_irq_rst_pulse #(.PULSE_LEN(PULSE_LEN)) u_rst_pulse (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (fire_rst),
      .req   (plat_rst_req)
   );

   for (genvar b = 0; b < NSRC; b++) begin : g_cause
      if (b == RSW_BIT) begin : g_rsw
         assign cause[b] = rsw_latched;
      end else if (b == STATE_BIT) begin : g_state
         assign cause[b] = rsw_sync[0];
      end else begin : g_level
         assign cause[b] = src_sync[b];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            mask_q <= '0;
      else if (bus_wr && sel == ACC_MASK)    mask_q <= bus_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cpu_irq <= 1'b0;
      else        cpu_irq <= |(cause & mask_q & IRQ_BITS);
   end

   always_comb begin
      unique case (sel)
         ACC_CAUSE: bus_rdata = cause;
         ACC_MASK:  bus_rdata = mask_q;
         default:   bus_rdata = '0;
      endcase
   end

   assert_mask_write_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == OFF_MASK) |=> (mask_q == $past(bus_wdata)));
   assert_masked_quiet_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mask_q) == '0) |-> !cpu_irq);
   assert_level_stable_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == OFF_CAUSE && $stable(src_sync)) |=>
      ((cause & LEVEL_BITS) == ($past(cause) & LEVEL_BITS)));
endmodule

// File: tb/lvl_irq_ctrl_bench.sv
`timescale 1ns/1ps
module lvl_irq_ctrl_bench;
   localparam int PER = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] src_lvl = '0;
   logic        rsw_n = 1'b1;
   logic        cpu_irq;
   logic        plat_rst_req;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   always #(PER/2) clk = ~clk;

   lvl_irq_ctrl u_lvl_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_lvl(src_lvl),
      .rsw_n(rsw_n), .cpu_irq(cpu_irq), .plat_rst_req(plat_rst_req));

   // behavioural reference: delay queues for synchronizers, integers for state
   logic [31:0] q_src [$];
   bit          q_sw  [$];
   bit          m_sw_prev, m_latch, m_irq;
   logic [31:0] m_mask;
   int          m_cnt;

   function automatic logic [31:0] m_cause();
      logic [31:0] c;
      c = q_src[0];
      c[1]  = m_latch;
      c[16] = q_sw[0];
      return c;
   endfunction

   function automatic logic [31:0] m_rdata();
      case (bus_addr)
         8'h00:   return m_cause();
         8'h04:   return m_mask;
         default: return 32'h0;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_src = '{32'h0, 32'h0};
         q_sw  = '{1'b1, 1'b1};
         m_sw_prev = 1; m_latch = 0; m_irq = 0; m_mask = '0; m_cnt = 0;
      end else begin
         bit press;
         logic [31:0] c;
         c = m_cause();
         press = m_sw_prev && !q_sw[0];
         m_irq = |(c & m_mask & ~32'h0001_0000);
         if (press) m_latch = 1;
         else if (bus_wr && bus_addr == 8'h00 && bus_wdata[1]) m_latch = 0;
         if (bus_wr && bus_addr == 8'h04) m_mask = bus_wdata;
         if (bus_wr && bus_addr == 8'h24 && bus_wdata == 0) m_cnt = 16;
         else if (m_cnt > 0) m_cnt--;
         m_sw_prev = q_sw[0];
         void'(q_src.pop_front()); q_src.push_back(src_lvl);
         void'(q_sw.pop_front());  q_sw.push_back(rsw_n);
      end
   end

   task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got=%08h exp=%08h t=%0t", tag, got, exp, $time);
      end
   endtask

   // cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      #1;
      if (rst_n && !done) begin
         chk("R6 cpu_irq model", {31'b0, cpu_irq}, {31'b0, m_irq});
         chk("R7 plat_rst_req model", {31'b0, plat_rst_req}, {31'b0, m_cnt > 0});
         chk("R1/R3/R5/R9 rdata model", bus_rdata, m_rdata());
      end
   end

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
      @(negedge clk);
      bus_addr = a;
      #2 chk(tag, bus_rdata, exp);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      #(PER * 200000);
      n_bad++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      int highs;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      rd(8'h00, 32'h0001_0000, "R5 reset cause");
      rd(8'h04, 32'h0, "R2 mask reset");
      chk("R6 irq after reset", {31'b0, cpu_irq}, 32'h0);

      wr(8'h04, 32'hFFFF_FFFF);
      rd(8'h04, 32'hFFFF_FFFF, "R2 mask readback");
      idle(2);
      chk("R5 state bit not an irq", {31'b0, cpu_irq}, 32'h0);

      src_lvl = 32'h0000_0100;
      idle(3);
      rd(8'h00, 32'h0001_0100, "R1 level set");
      chk("R6 irq on enabled level", {31'b0, cpu_irq}, 32'h1);
      wr(8'h00, 32'hFFFF_FFFF);
      rd(8'h00, 32'h0001_0100, "R4 all-ones keeps level");
      src_lvl = 32'h0;
      idle(3);
      rd(8'h00, 32'h0001_0000, "R1 level drops");

      src_lvl = 32'h0001_0002;
      idle(4);
      rd(8'h00, 32'h0001_0000, "R10 sources 1,16 ignored");
      chk("R10 no irq", {31'b0, cpu_irq}, 32'h0);
      src_lvl = 32'h0;

      rsw_n = 1'b0;
      idle(4);
      rd(8'h00, 32'h0000_0002, "R3 press latched, R5 held");
      rsw_n = 1'b1;
      idle(4);
      rd(8'h00, 32'h0001_0002, "R3 latch holds after release");
      wr(8'h00, 32'hFFFF_FFFD);
      rd(8'h00, 32'h0001_0002, "R4 zero in bit1 keeps latch");
      wr(8'h00, 32'h0000_0002);
      rd(8'h00, 32'h0001_0000, "R4 w1c clears latch");

      // press edge and clearing write on the same clock edge
      @(negedge clk);
      rsw_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      bus_addr = 8'h00; bus_wdata = 32'h2; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      rd(8'h00, 32'h0000_0002, "R4 set wins over clear");
      rsw_n = 1'b1;
      idle(3);

      wr(8'h04, 32'h0000_0002);
      idle(1);
      chk("R6 irq from latched cause", {31'b0, cpu_irq}, 32'h1);
      wr(8'h04, 32'h0);
      idle(1);
      chk("R6 irq off when masked", {31'b0, cpu_irq}, 32'h0);
      wr(8'h00, 32'h2);

      wr(8'h24, 32'h0000_0005);
      highs = 0;
      for (int i = 0; i < 20; i++) begin
         #2 if (plat_rst_req) highs++;
         @(negedge clk);
      end
      chk("R8 nonzero write ignored", highs, 0);

      wr(8'h24, 32'h0);
      highs = 0;
      for (int i = 0; i < 24; i++) begin
         #2 if (plat_rst_req) highs++;
         @(negedge clk);
      end
      chk("R7 pulse width", highs, 16);

      wr(8'h24, 32'h0);
      idle(7);
      wr(8'h24, 32'h0);
      highs = 0;
      for (int i = 0; i < 24; i++) begin
         #2 if (plat_rst_req) highs++;
         @(negedge clk);
      end
      chk("R7 retrigger restarts", highs, 16);

      rd(8'h24, 32'h0, "R9 reset reg reads zero");
      rd(8'h08, 32'h0, "R9 unmapped reads zero");
      rd(8'hFC, 32'h0, "R9 high unmapped reads zero");

      idle(2);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule